// File: doc/BRIEF.md
# Floating-Point Operand Alignment Stage

This block is one pipeline stage in front of a floating-point adder. It takes two unpacked operands. Each operand has a sign, a biased exponent and a mantissa field. The mantissa field holds the hidden bit at its top, followed by the fraction, followed by a few low-order guard positions. The stage compares the two exponents and picks the operand with the smaller exponent. It shifts that operand's mantissa toward the least significant end by the full exponent difference, in one variable-width shift within one clock cycle. Any nonzero bits pushed out of the field are folded into a sticky bit, which is ORed into bit 0 of the shifted mantissa.

The result leaves through a registered valid/ready handshake. It carries both signs unchanged, both aligned mantissas, and one shared exponent equal to the larger input exponent. The adder behind the stage can then combine the two mantissas directly. Special values, the addition, normalisation and rounding are handled elsewhere.

Top module: `fpa_align_stage`

## Requirements
- R1: While rst_ni is low and after it is released, out_valid_o is 0 and in_ready_o is 1 until an operand pair is accepted.
- R2: For an accepted pair, exp_o equals the larger of a_exp_i and b_exp_i.
- R3: The operand whose exponent is greater than or equal to the other one keeps its mantissa bit-exact. Both signs appear unchanged on a_sign_o and b_sign_o.
- R4: The mantissa of the operand with the strictly smaller exponent is shifted right by d, the absolute exponent difference, with zeros entering at the top (bit FRAC_W-1).
- R5: Bit 0 of the shifted mantissa is the OR of the bit shifted into position 0 and every bit shifted out below position 0. When every bit shifted out is zero, nothing is added.
- R6: When the exponents are equal, both mantissas pass through unchanged and no sticky bit is added.
- R7: When d is at least FRAC_W (26 by default), the shifted mantissa is 0 if the original was 0, and 1 (only bit 0 set) otherwise.
- R8: A pair is accepted on a rising edge where in_valid_i and in_ready_o are both high. out_valid_o is high from that edge on. out_valid_o falls after an edge with out_ready_i high and nothing new accepted.
- R9: While out_valid_o is high and out_ready_i is low, all outputs hold their values.
- R10: in_ready_o is high exactly when the output register is empty or out_ready_i is high. A drain and a new accept can therefore happen on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand pair present |
| in_ready_o | output | 1 | Stage can take a pair |
| a_sign_i | input | 1 | Sign of operand A |
| a_exp_i | input | EXP_W | Biased exponent of A |
| a_man_i | input | FRAC_W | Mantissa of A with hidden bit and guard positions |
| b_sign_i | input | 1 | Sign of operand B |
| b_exp_i | input | EXP_W | Biased exponent of B |
| b_man_i | input | FRAC_W | Mantissa of B with hidden bit and guard positions |
| out_valid_o | output | 1 | Aligned pair present |
| out_ready_i | input | 1 | Consumer takes the pair |
| a_sign_o | output | 1 | Sign of A |
| a_man_o | output | FRAC_W | Aligned mantissa of A |
| b_sign_o | output | 1 | Sign of B |
| b_man_o | output | FRAC_W | Aligned mantissa of B |
| exp_o | output | EXP_W | Shared exponent |

## Verification
Equal exponents show whether any shift or sticky bit leaks into an operand that should pass through. A larger exponent on one side and then on the other shows whether the right operand is chosen. Small differences are tried both with only zeros falling off the bottom and with ones falling off. This separates a correct sticky mask from an off-by-one mask, and from a sticky bit that is missing or always set. Differences of 25, 26 and far beyond, with zero and nonzero mantissas, probe the saturation edge. Random pairs compared against a one-bit-at-a-time shift model cover everything in between, and a stalled consumer probes holding, draining and same-edge refill.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
  localparam int unsigned EXP_W_DEF = 8;
  localparam int unsigned MAN_W_DEF = 24;
  localparam int unsigned GRD_W_DEF = 2;

  typedef enum logic {
    SEL_SHIFT_B = 1'b0,
    SEL_SHIFT_A = 1'b1
  } shift_sel_e;
endpackage

// File: rtl/fpa_exp_cmp.sv
module fpa_exp_cmp #(
  parameter int unsigned EXP_W = 8
) (
  input  logic [EXP_W-1:0]  a_exp_i,
  input  logic [EXP_W-1:0]  b_exp_i,
  output fpa_pkg::shift_sel_e sel_o,
  output logic [EXP_W-1:0]  diff_o,
  output logic [EXP_W-1:0]  exp_max_o
);
  logic b_gt;

  assign b_gt      = b_exp_i > a_exp_i;
  assign sel_o     = b_gt ? fpa_pkg::SEL_SHIFT_A : fpa_pkg::SEL_SHIFT_B;
  assign diff_o    = b_gt ? (b_exp_i - a_exp_i) : (a_exp_i - b_exp_i);
  // smaller exponent raised by adding the difference
  assign exp_max_o = b_gt ? (a_exp_i + diff_o) : (b_exp_i + diff_o);
endmodule

// File: rtl/fpa_sticky_shift.sv
module fpa_sticky_shift #(
  parameter int unsigned FRAC_W = 26,
  parameter int unsigned SH_W   = 8
) (
  input  logic [FRAC_W-1:0] man_i,
  input  logic [SH_W-1:0]   shamt_i,
  output logic [FRAC_W-1:0] man_o
);
  localparam logic [FRAC_W-1:0] ONES = {FRAC_W{1'b1}};

  logic              sat;
  logic [FRAC_W-1:0] shifted;
  logic [FRAC_W-1:0] lost_mask;
  logic              sticky;

  assign sat       = int'(shamt_i) >= int'(FRAC_W);
  assign shifted   = sat ? '0 : (man_i >> shamt_i);
  // ones in the positions that fall off the bottom
  assign lost_mask = sat ? ONES : ~(ONES << shamt_i);
  assign sticky    = |(man_i & lost_mask);
  assign man_o     = {shifted[FRAC_W-1:1], shifted[0] | sticky};
endmodule

// File: rtl/fpa_align_stage.sv
module fpa_align_stage #(
  parameter int unsigned EXP_W = fpa_pkg::EXP_W_DEF,
  parameter int unsigned MAN_W = fpa_pkg::MAN_W_DEF,
  parameter int unsigned GRD_W = fpa_pkg::GRD_W_DEF
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_valid_i,
  output logic                     in_ready_o,
  input  logic                     a_sign_i,
  input  logic [EXP_W-1:0]         a_exp_i,
  input  logic [MAN_W+GRD_W-1:0]   a_man_i,
  input  logic                     b_sign_i,
  input  logic [EXP_W-1:0]         b_exp_i,
  input  logic [MAN_W+GRD_W-1:0]   b_man_i,
  output logic                     out_valid_o,
  input  logic                     out_ready_i,
  output logic                     a_sign_o,
  output logic [MAN_W+GRD_W-1:0]   a_man_o,
  output logic                     b_sign_o,
  output logic [MAN_W+GRD_W-1:0]   b_man_o,
  output logic [EXP_W-1:0]         exp_o
);
  localparam int unsigned FRAC_W = MAN_W + GRD_W;

  fpa_pkg::shift_sel_e sel;
  logic [EXP_W-1:0]    diff;
  logic [EXP_W-1:0]    exp_max;
  logic [FRAC_W-1:0]   sh_in;
  logic [FRAC_W-1:0]   sh_out;
  logic [FRAC_W-1:0]   a_al;
  logic [FRAC_W-1:0]   b_al;
  logic                accept;

  fpa_exp_cmp #(.EXP_W(EXP_W)) i_cmp (
    .a_exp_i   (a_exp_i),
    .b_exp_i   (b_exp_i),
    .sel_o     (sel),
    .diff_o    (diff),
    .exp_max_o (exp_max)
  );

  assign sh_in = (sel == fpa_pkg::SEL_SHIFT_A) ? a_man_i : b_man_i;

  fpa_sticky_shift #(.FRAC_W(FRAC_W), .SH_W(EXP_W)) i_shift (
    .man_i   (sh_in),
    .shamt_i (diff),
    .man_o   (sh_out)
  );

  assign a_al = (sel == fpa_pkg::SEL_SHIFT_A) ? sh_out : a_man_i;
  assign b_al = (sel == fpa_pkg::SEL_SHIFT_A) ? b_man_i : sh_out;

  assign in_ready_o = ~out_valid_o | out_ready_i;
  assign accept     = in_valid_i & in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
    end else if (accept) begin
      out_valid_o <= 1'b1;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_sign_o <= 1'b0;
      b_sign_o <= 1'b0;
      a_man_o  <= '0;
      b_man_o  <= '0;
      exp_o    <= '0;
    end else if (accept) begin
      a_sign_o <= a_sign_i;
      b_sign_o <= b_sign_i;
      a_man_o  <= a_al;
      b_man_o  <= b_al;
      exp_o    <= exp_max;
    end
  end
endmodule

// File: rtl/fpa_align_chk.sv
module fpa_align_chk #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 26
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              a_sign_i,
  input logic [EXP_W-1:0]  a_exp_i,
  input logic [FRAC_W-1:0] a_man_i,
  input logic              b_sign_i,
  input logic [EXP_W-1:0]  b_exp_i,
  input logic [FRAC_W-1:0] b_man_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic              a_sign_o,
  input logic [FRAC_W-1:0] a_man_o,
  input logic              b_sign_o,
  input logic [FRAC_W-1:0] b_man_o,
  input logic [EXP_W-1:0]  exp_o
);
  p_accept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o);

  p_drain_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && !in_valid_i |=> !out_valid_o);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(a_man_o) &&
      $stable(b_man_o) && $stable(exp_o) && $stable(a_sign_o) && $stable(b_sign_o));

  p_stall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o);

  p_exp_max_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=>
      exp_o == (($past(a_exp_i) > $past(b_exp_i)) ? $past(a_exp_i) : $past(b_exp_i)));

  p_keep_big_a_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && a_exp_i >= b_exp_i |=> a_man_o == $past(a_man_i));

  p_keep_big_b_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && b_exp_i >= a_exp_i |=> b_man_o == $past(b_man_i));

  p_signs_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> a_sign_o == $past(a_sign_i) && b_sign_o == $past(b_sign_i));

  p_reset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rst_ni) |-> !out_valid_o);
endmodule

bind fpa_align_stage fpa_align_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_chk (.*);

// File: tb/test_fpa_align_stage.sv
module test_fpa_align_stage;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 26;

  typedef struct packed {
    logic [EXP_W-1:0]  ae;
    logic [EXP_W-1:0]  be;
    logic [FRAC_W-1:0] am;
    logic [FRAC_W-1:0] bm;
    logic              as_;
    logic              bs_;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{8'd100, 8'd100, 26'h2ABCDEF, 26'h3000001, 1'b0, 1'b1}, // equal
    '{8'd101, 8'd100, 26'h2000000, 26'h2000004, 1'b1, 1'b0}, // d1, zero lost
    '{8'd101, 8'd100, 26'h2000000, 26'h2000005, 1'b0, 1'b0}, // d1, one lost
    '{8'd100, 8'd102, 26'h2000003, 26'h3FFFFFF, 1'b1, 1'b1}, // d2 shift A, lost 11
    '{8'd100, 8'd103, 26'h2000008, 26'h2000000, 1'b0, 1'b1}, // d3 lost 000
    '{8'd100, 8'd103, 26'h2000004, 26'h2000000, 1'b0, 1'b1}, // d3 lost 100
    '{8'd130, 8'd105, 26'h2000000, 26'h3FFFFFF, 1'b0, 1'b0}, // d25
    '{8'd130, 8'd104, 26'h2000000, 26'h2000000, 1'b1, 1'b0}, // d26 nonzero
    '{8'd130, 8'd104, 26'h2000000, 26'h0000000, 1'b0, 1'b1}, // d26 zero
    '{8'd10,  8'd210, 26'h0000001, 26'h2000000, 1'b1, 1'b1}, // d200
    '{8'd255, 8'd0,   26'h3FFFFFF, 26'h0000001, 1'b0, 1'b0}, // d255
    '{8'd60,  8'd64,  26'h2000010, 26'h2000000, 1'b0, 1'b0}, // d4 lost 0000 exact
    '{8'd64,  8'd60,  26'h2000000, 26'h2000011, 1'b1, 1'b0}, // d4 lost 0001
    '{8'd0,   8'd0,   26'h0000000, 26'h0000003, 1'b0, 1'b1}  // equal, guard bits
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              in_valid_i = 1'b0;
  logic              in_ready_o;
  logic              a_sign_i = 1'b0;
  logic [EXP_W-1:0]  a_exp_i = '0;
  logic [FRAC_W-1:0] a_man_i = '0;
  logic              b_sign_i = 1'b0;
  logic [EXP_W-1:0]  b_exp_i = '0;
  logic [FRAC_W-1:0] b_man_i = '0;
  logic              out_valid_o;
  logic              out_ready_i = 1'b1;
  logic              a_sign_o;
  logic [FRAC_W-1:0] a_man_o;
  logic              b_sign_o;
  logic [FRAC_W-1:0] b_man_o;
  logic [EXP_W-1:0]  exp_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  fpa_align_stage i_fpa_align_stage (.*);

  function automatic logic [FRAC_W-1:0] ref_shift(logic [FRAC_W-1:0] m, int d);
    logic st = 1'b0;
    for (int i = 0; i < d; i++) begin
      st = st | m[0];
      m  = m >> 1;
    end
    m[0] = m[0] | st;
    return m;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(vec_t v);
    a_exp_i = v.ae; b_exp_i = v.be; a_man_i = v.am; b_man_i = v.bm;
    a_sign_i = v.as_; b_sign_i = v.bs_;
  endtask

  task automatic check_out(vec_t v);
    int d;
    string tag;
    logic [FRAC_W-1:0] ea, eb;
    d  = (v.ae > v.be) ? int'(v.ae) - int'(v.be) : int'(v.be) - int'(v.ae);
    ea = (v.be > v.ae) ? ref_shift(v.am, d) : v.am;
    eb = (v.ae > v.be) ? ref_shift(v.bm, d) : v.bm;
    tag = (d == 0) ? "R6" : (d >= FRAC_W) ? "R7" : "R4_R5";
    chk(out_valid_o === 1'b1, "R8", 64'(out_valid_o), 64'd1);
    chk(exp_o === ((v.ae > v.be) ? v.ae : v.be), "R2", 64'(exp_o),
        64'((v.ae > v.be) ? v.ae : v.be));
    chk(a_man_o === ea, tag, 64'(a_man_o), 64'(ea));
    chk(b_man_o === eb, tag, 64'(b_man_o), 64'(eb));
    chk(a_sign_o === v.as_ && b_sign_o === v.bs_, "R3",
        64'({a_sign_o, b_sign_o}), 64'({v.as_, v.bs_}));
  endtask

  // one pair through with a ready consumer
  task automatic run_one(vec_t v);
    @(negedge clk_i);
    drive(v);
    in_valid_i  = 1'b1;
    out_ready_i = 1'b1;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    check_out(v);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    vec_t v, w;
    repeat (3) @(negedge clk_i);
    chk(out_valid_o === 1'b0, "R1", 64'(out_valid_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(out_valid_o === 1'b0 && in_ready_o === 1'b1, "R1",
        64'({out_valid_o, in_ready_o}), 64'b01);

    foreach (VECS[i]) run_one(VECS[i]);

    for (int k = 0; k < 300; k++) begin
      int dd;
      v.ae  = EXP_W'($urandom_range(0, 255));
      dd    = (k % 5 == 0) ? int'($urandom_range(0, 255)) : int'($urandom_range(0, 30));
      v.be  = ($urandom_range(0, 1) == 1) ? EXP_W'(int'(v.ae) + dd) : EXP_W'(int'(v.ae) - dd);
      v.am  = FRAC_W'($urandom);
      v.bm  = FRAC_W'($urandom);
      v.as_ = 1'($urandom);
      v.bs_ = 1'($urandom);
      run_one(v);
    end

    // drained with nothing new: R8
    @(negedge clk_i);
    chk(out_valid_o === 1'b0, "R8", 64'(out_valid_o), 64'd0);

    // stall: R9, R10
    v = VECS[3];
    w = VECS[12];
    @(negedge clk_i);
    out_ready_i = 1'b0;
    drive(v);
    in_valid_i = 1'b1;
    @(negedge clk_i);
    drive(w);
    chk(in_ready_o === 1'b0, "R10", 64'(in_ready_o), 64'd0);
    repeat (3) @(negedge clk_i);
    check_out(v);
    chk(in_ready_o === 1'b0, "R9", 64'(in_ready_o), 64'd0);
    out_ready_i = 1'b1;
    #0.5;
    chk(in_ready_o === 1'b1, "R10", 64'(in_ready_o), 64'd1);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    check_out(w);
    @(negedge clk_i);
    chk(out_valid_o === 1'b0, "R8", 64'(out_valid_o), 64'd0);

    // reset during a held result: R1
    out_ready_i = 1'b0;
    run_one(VECS[0]);
    out_ready_i = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(out_valid_o === 1'b0 && in_ready_o === 1'b1, "R1",
        64'({out_valid_o, in_ready_o}), 64'b01);
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule